// File: doc/BRIEF.md
# Frame-Indexed Translation Table Walker

This block translates a virtual page number, tagged with a process identifier, into a physical frame. Its table has exactly one slot per physical frame, so a slot's position is its frame number. The table's size is therefore set by physical memory and does not grow with the number of processes or pages. A lookup folds the page number into a slot index. It compares the key stored there and, on a mismatch, follows that slot's successor pointer. The walk examines one slot per clock cycle until it finds a match or meets the end of the chain.

Requests enter on a valid/ready handshake. A request is taken on a cycle where both `req_valid` and `req_ready` are high. `req_ready` is low for the whole walk. A `req_valid` raised during that time is ignored, not held: the requester must present the request again once `req_ready` returns. Results leave as a one-cycle `res_valid` pulse with no back-pressure, so the consumer must capture them in that cycle.

Table slots are loaded through a plain single-cycle write port. The policy that decides what goes into the slots belongs to the surrounding system.

Top module: `ipt_lookup`

## Requirements
- R1: After reset `req_ready` is 1 and `res_valid` is 0. Every slot is cleared: its used flag is 0 and its successor pointer is 0.
- R2: The first slot examined is the XOR of the page number's 6-bit slices, where slice k is bits [6k+5:6k] and the top slice is zero-padded. A hit in that first slot raises `res_valid` on the first rising edge after the accepting edge.
- R3: A slot matches only when its used flag is 1 and both its stored page number and stored process identifier equal the request's.
- R4: The walk examines one slot per cycle, following successor pointers. A hit at chain position k (head is 0) raises `res_valid` k+1 edges after acceptance, and `res_frame` equals the index of the matching slot.
- R5: A slot whose successor pointer equals its own index ends the chain. If that slot does not match, the result is a miss.
- R6: After 64 slots have been examined with no match and no chain end, the walk reports a miss, 64 edges after acceptance.
- R7: On a hit, `res_paddr` is {frame, request offset}. On a miss, `res_hit`, `res_frame` and `res_paddr` are 0.
- R8: While a walk is in progress, `req_ready` is 0. A `req_valid` in that time produces no result of its own and does not alter the result in flight.
- R9: A write with `wr_en` stores page number, process identifier, used flag and successor pointer into slot `wr_idx` at the next edge. Lookups accepted afterwards see the new contents. A slot whose used flag is 0 never matches, but its successor pointer is still followed.
- R10: Each accepted request yields exactly one `res_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_vpn | input | 20 | Virtual page number |
| req_pid | input | 8 | Process identifier |
| req_off | input | 12 | Byte offset within the page |
| wr_en | input | 1 | Write one table slot |
| wr_idx | input | 6 | Slot (frame) being written |
| wr_vpn | input | 20 | Page number to store |
| wr_pid | input | 8 | Process identifier to store |
| wr_used | input | 1 | Used flag to store |
| wr_next | input | 6 | Successor pointer to store |
| res_valid | output | 1 | One-cycle result pulse |
| res_hit | output | 1 | Translation found |
| res_frame | output | 6 | Matching frame number |
| res_paddr | output | 18 | Frame joined with offset |

## Verification
The bench builds the block with its defaults: 6 index bits (64 frames), 20-bit page numbers, 8-bit process identifiers and 12-bit offsets. With 64 slots a fully circular chain can be built by hand, which makes the 64-step cut-off reachable. Random tables with page numbers drawn from a small set make hashes collide often. Random successor pointers produce self-ends, loops and chains through unused slots. The bench predicts every one of these outcomes, including latency, with its own walk model.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_state_t;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W = 20,
  parameter int IDX_W = 6
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] idx
);
  localparam int NSL    = (VPN_W + IDX_W - 1) / IDX_W;
  localparam int FULL_W = NSL * IDX_W;

  logic [FULL_W-1:0]           padded;
  logic [NSL:0][IDX_W-1:0]     acc;

  assign padded = FULL_W'(vpn);
  assign acc[0] = '0;

  for (genvar g = 0; g < NSL; g++) begin : g_fold
    assign acc[g+1] = acc[g] ^ padded[g*IDX_W +: IDX_W];
  end

  assign idx = acc[NSL];
endmodule

// File: rtl/ipt_store.sv
module ipt_store #(
  parameter int IDX_W = 6,
  parameter int VPN_W = 20,
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic             wr_used,
  input  logic [IDX_W-1:0] wr_next,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [PID_W-1:0] rd_pid,
  output logic             rd_used,
  output logic [IDX_W-1:0] rd_next
);
  localparam int N = 1 << IDX_W;

  logic [VPN_W-1:0] ent_vpn  [N];
  logic [PID_W-1:0] ent_pid  [N];
  logic             ent_used [N];
  logic [IDX_W-1:0] ent_next [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        ent_vpn[i]  <= '0;
        ent_pid[i]  <= '0;
        ent_used[i] <= 1'b0;
        ent_next[i] <= '0;
      end
    end else if (wr_en) begin
      ent_vpn[wr_idx]  <= wr_vpn;
      ent_pid[wr_idx]  <= wr_pid;
      ent_used[wr_idx] <= wr_used;
      ent_next[wr_idx] <= wr_next;
    end
  end

  assign rd_vpn  = ent_vpn[rd_idx];
  assign rd_pid  = ent_pid[rd_idx];
  assign rd_used = ent_used[rd_idx];
  assign rd_next = ent_next[rd_idx];
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PID_W-1:0] req_pid,
  input  logic [OFF_W-1:0] req_off,
  input  logic [IDX_W-1:0] start_idx,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [VPN_W-1:0] rd_vpn,
  input  logic [PID_W-1:0] rd_pid,
  input  logic             rd_used,
  input  logic [IDX_W-1:0] rd_next,
  output logic             res_valid,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_frame,
  output logic [OFF_W-1:0] res_off
);
  localparam logic [IDX_W-1:0] LAST_STEP = {IDX_W{1'b1}};

  walk_state_t      state;
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] steps;
  logic [VPN_W-1:0] key_vpn;
  logic [PID_W-1:0] key_pid;
  logic [OFF_W-1:0] key_off;
  logic             busy;
  logic             match;
  logic             chain_end;

  assign busy      = (state == ST_WALK);
  assign req_ready = (state == ST_IDLE);
  assign rd_idx    = cur_idx;
  assign match     = rd_used && (rd_vpn == key_vpn) && (rd_pid == key_pid);
  assign chain_end = (rd_next == cur_idx) || (steps == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_idx   <= '0;
      steps     <= '0;
      key_vpn   <= '0;
      key_pid   <= '0;
      key_off   <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_frame <= '0;
      res_off   <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state   <= ST_WALK;
            cur_idx <= start_idx;
            steps   <= '0;
            key_vpn <= req_vpn;
            key_pid <= req_pid;
            key_off <= req_off;
          end
        end
        ST_WALK: begin
          if (match) begin
            state     <= ST_IDLE;
            res_valid <= 1'b1;
            res_hit   <= 1'b1;
            res_frame <= cur_idx;
            res_off   <= key_off;
          end else if (chain_end) begin
            state     <= ST_IDLE;
            res_valid <= 1'b1;
            res_hit   <= 1'b0;
            res_frame <= '0;
            res_off   <= '0;
          end else begin
            cur_idx <= rd_next;
            steps   <= steps + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  function automatic logic [IDX_W-1:0] fold_ref(input logic [VPN_W-1:0] v);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < VPN_W; i++) h[i % IDX_W] ^= v[i];
    return h;
  endfunction

  // R8: a taken request makes the block busy on the next cycle
  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R2: walk starts at the folded slice index of the stored key
  assert_start_at_fold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cur_idx == fold_ref(key_vpn)));

  // R4: consecutive walk cycles follow the successor pointer read from the table
  assert_follow_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cur_idx == $past(rd_next)));

  // R10: every result pulse closes a walk
  assert_result_after_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy));

  // R3: a hit only ever comes from a used slot
  assert_hit_from_used_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> $past(rd_used));
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int IDX_W = 6,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [PID_W-1:0]       req_pid,
  input  logic [OFF_W-1:0]       req_off,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [VPN_W-1:0]       wr_vpn,
  input  logic [PID_W-1:0]       wr_pid,
  input  logic                   wr_used,
  input  logic [IDX_W-1:0]       wr_next,
  output logic                   res_valid,
  output logic                   res_hit,
  output logic [IDX_W-1:0]       res_frame,
  output logic [IDX_W+OFF_W-1:0] res_paddr
);
  logic [IDX_W-1:0] start_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [VPN_W-1:0] rd_vpn;
  logic [PID_W-1:0] rd_pid;
  logic             rd_used;
  logic [IDX_W-1:0] rd_next;
  logic [OFF_W-1:0] res_off;

  ipt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
    .vpn (req_vpn),
    .idx (start_idx)
  );

  ipt_store #(.IDX_W(IDX_W), .VPN_W(VPN_W), .PID_W(PID_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_vpn  (wr_vpn),
    .wr_pid  (wr_pid),
    .wr_used (wr_used),
    .wr_next (wr_next),
    .rd_idx  (rd_idx),
    .rd_vpn  (rd_vpn),
    .rd_pid  (rd_pid),
    .rd_used (rd_used),
    .rd_next (rd_next)
  );

  ipt_walker #(.IDX_W(IDX_W), .VPN_W(VPN_W), .PID_W(PID_W), .OFF_W(OFF_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vpn   (req_vpn),
    .req_pid   (req_pid),
    .req_off   (req_off),
    .start_idx (start_idx),
    .rd_idx    (rd_idx),
    .rd_vpn    (rd_vpn),
    .rd_pid    (rd_pid),
    .rd_used   (rd_used),
    .rd_next   (rd_next),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_frame (res_frame),
    .res_off   (res_off)
  );

  assign res_paddr = {res_frame, res_off};

  // R7: a miss never carries a translated address
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_paddr == '0));
endmodule

// File: tb/sim_ipt_lookup.sv
`timescale 1ns/1ps
module sim_ipt_lookup;
  localparam int IW = 6;
  localparam int VW = 20;
  localparam int PW = 8;
  localparam int OW = 12;
  localparam int N  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [VW-1:0] req_vpn = '0;
  logic [PW-1:0] req_pid = '0;
  logic [OW-1:0] req_off = '0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [VW-1:0] wr_vpn = '0;
  logic [PW-1:0] wr_pid = '0;
  logic          wr_used = 1'b0;
  logic [IW-1:0] wr_next = '0;
  logic          res_valid;
  logic          res_hit;
  logic [IW-1:0] res_frame;
  logic [IW+OW-1:0] res_paddr;

  int n_checks = 0;
  int n_fails  = 0;

  logic [VW-1:0] m_vpn  [N];
  logic [PW-1:0] m_pid  [N];
  logic          m_used [N];
  logic [IW-1:0] m_next [N];

  always #2.5 clk = ~clk;

  ipt_lookup #(.IDX_W(IW), .VPN_W(VW), .PID_W(PW), .OFF_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_pid(req_pid), .req_off(req_off),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pid(wr_pid),
    .wr_used(wr_used), .wr_next(wr_next),
    .res_valid(res_valid), .res_hit(res_hit), .res_frame(res_frame),
    .res_paddr(res_paddr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [IW-1:0] fold(input logic [VW-1:0] v);
    logic [IW-1:0] h = '0;
    for (int i = 0; i < VW; i++) h[i % IW] ^= v[i];
    return h;
  endfunction

  task automatic model_walk(input logic [VW-1:0] v, input logic [PW-1:0] p,
                            output bit hit, output int frame, output int lat);
    int idx = int'(fold(v));
    hit = 0; frame = 0; lat = N;
    for (int s = 0; s < N; s++) begin
      if (m_used[idx] && m_vpn[idx] == v && m_pid[idx] == p) begin
        hit = 1; frame = idx; lat = s + 1; return;
      end
      if (int'(m_next[idx]) == idx) begin
        lat = s + 1; return;
      end
      idx = int'(m_next[idx]);
    end
  endtask

  task automatic put(input int idx, input logic [VW-1:0] v, input logic [PW-1:0] p,
                     input logic u, input int nxt);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_vpn = v; wr_pid = p; wr_used = u; wr_next = IW'(nxt);
    m_vpn[idx] = v; m_pid[idx] = p; m_used[idx] = u; m_next[idx] = IW'(nxt);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [VW-1:0] v, input logic [PW-1:0] p,
                        input logic [OW-1:0] off, input string req, input bit inject);
    bit e_hit; int e_frame; int e_lat; int lat;
    logic [IW+OW-1:0] e_pa;
    model_walk(v, p, e_hit, e_frame, e_lat);
    e_pa = e_hit ? {IW'(e_frame), off} : '0;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = v; req_pid = p; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      chk(req_ready == 1'b0, "R8 ready during walk", req_ready, 0);
      req_valid = 1'b1; req_vpn = v ^ 20'h1; req_pid = p ^ 8'h1; req_off = ~off;
    end
    lat = 0;
    while (!res_valid && lat < 100) begin
      @(negedge clk);
      lat++;
      req_valid = 1'b0;
    end
    chk(lat == e_lat, {req, " R4 latency"}, lat, e_lat);
    chk(res_hit == e_hit, {req, " R3 hit"}, res_hit, e_hit);
    chk(res_frame == IW'(e_hit ? e_frame : 0), {req, " R4 frame"}, res_frame, e_frame);
    chk(res_paddr == e_pa, {req, " R7 paddr"}, res_paddr, e_pa);
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 single pulse", res_valid, 0);
    if (inject) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk(res_valid == 1'b0, "R8 no extra result", res_valid, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [VW-1:0] va, vb;
    int h, far;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_pid[i] = '0; m_used[i] = 1'b0; m_next[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(res_valid == 1'b0, "R1 no result after reset", res_valid, 0);
    lookup(20'h3A5C7, 8'h11, 12'h123, "R1 empty table", 0);

    // R2/R7: head hit at the folded index
    va = 20'h5B2E1;
    h  = int'(fold(va));
    put(h, va, 8'h21, 1'b1, h);
    lookup(va, 8'h21, 12'hABC, "R2 head hit", 0);
    // R3/R5: same page, other process -> miss at self-ending head
    lookup(va, 8'h22, 12'h001, "R3 pid mismatch R5", 0);
    // R9: unused slot never matches
    put(h, va, 8'h21, 1'b0, h);
    lookup(va, 8'h21, 12'h002, "R9 unused slot", 0);

    // R4/R9: head mismatch, pass through unused slot, hit at depth 2
    vb = 20'h0F00D;
    h  = int'(fold(vb));
    put(h, 20'h11111, 8'h05, 1'b1, (h + 7) % N);
    put((h + 7) % N, vb, 8'h05, 1'b0, (h + 20) % N);
    put((h + 20) % N, vb, 8'h05, 1'b1, (h + 20) % N);
    lookup(vb, 8'h05, 12'hFFF, "R4 chain depth", 0);

    // R6: full ring with no match
    for (int i = 0; i < N; i++) put(i, 20'hFFFFF, 8'hFF, 1'b1, (i + 1) % N);
    lookup(20'h12345, 8'h33, 12'h456, "R6 ring limit", 0);
    // R8: inject a request during the long walk
    lookup(20'h12345, 8'h33, 12'h457, "R8 ignored request", 1);
    // R4: far hit on the ring
    far = (int'(fold(20'h12345)) + 10) % N;
    put(far, 20'h12345, 8'h33, 1'b1, (far + 1) % N);
    lookup(20'h12345, 8'h33, 12'h458, "R4 far hit", 0);

    // Random tables and keys
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < N; i++) begin
        int nx;
        nx = ($urandom % 5 == 0) ? i : int'($urandom % N);
        put(i, VW'($urandom % 32), PW'($urandom % 4), ($urandom % 4) != 0, nx);
      end
      for (int q = 0; q < 120; q++) begin
        int e;
        e = int'($urandom % N);
        if ($urandom % 2)
          lookup(m_vpn[e], m_pid[e], OW'($urandom), "R4 random", 0);
        else
          lookup(VW'($urandom % 32), PW'($urandom % 4), OW'($urandom), "R2 random", 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule